// File: doc/BRIEF.md
# Horizontal Line Timing Measurement

This block times the horizontal structure of a video signal in cycles of the reference clock. A 12-bit cycle counter restarts on every leading edge of the horizontal sync, which has already been corrected to active-high. Six values are taken against that counter during a vertical frame:

- the width of the sync pulse
- the line period
- the earliest point in any line where picture content appears
- the latest point in any line where picture content ends
- the start of the flyback pulse
- the end of the flyback pulse

Picture content is present when any of the per-channel "above threshold" flags is high.

Results build up in working registers while the frame runs. On the leading edge of the vertical sync, which is also active-high, the working values move into a set of read registers and the working registers are cleared for the next frame. The read registers then hold still for the whole frame, so a host can read them at any moment. Each reading is a 16-bit word: the count sits in the upper bits and the lower bits are zero.

The outputs are plain held registers with no handshake. They change only in the cycle after a vertical leading edge, so a reader needs no back-pressure.

Top module: `hline_meas`

## Requirements
- R1: The line counter is 0 in the cycle in which the horizontal sync leading edge is seen, rises by one each cycle after that, and saturates at 4095 instead of wrapping.
- R2: The sync width is the counter value in the cycle in which the horizontal sync falling edge is seen. This equals the number of cycles the sync was high. The last such value in the frame is kept.
- R3: The line period is the number of cycles between two consecutive horizontal sync leading edges, saturated at 4095. The last value in the frame is kept.
- R4: Video start is the smallest counter value at which the OR of the three video channel flags rises, over all lines of the frame. Video end is the largest counter value at which that OR falls. Any single channel is enough.
- R5: A frame in which the combined video flag never rises reports 0 for video start. A frame in which it never falls reports 0 for video end.
- R6: Flyback start is the counter value at the last rising edge of the flyback pulse in the frame. Flyback end is the counter value at its last falling edge.
- R7: On the cycle in which the vertical sync leading edge is seen, the read registers load the results of the frame just ended, and they are visible from the next cycle. Any edge seen in that same cycle counts toward the new frame.
- R8: After reset every read register is 0. Between vertical leading edges the read registers do not change.
- R9: Each output is 16 bits wide, with the 12-bit count in bits 15:4 and bits 3:0 equal to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference measurement clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hsync_i | input | 1 | Polarity-corrected horizontal sync, active high |
| vsync_i | input | 1 | Polarity-corrected vertical sync, active high |
| flyback_i | input | 1 | Horizontal flyback pulse |
| video_i | input | 3 | Per-channel active-video flags |
| sync_width_o | output | 16 | Held horizontal sync width |
| line_period_o | output | 16 | Held line period |
| video_start_o | output | 16 | Held earliest video start |
| video_end_o | output | 16 | Held latest video end |
| flyback_start_o | output | 16 | Held flyback start |
| flyback_end_o | output | 16 | Held flyback end |

## Verification
Faults in this block become visible at only one point: the next vertical leading edge, one frame after the state went wrong. The bench therefore compares all six words at the start of every frame, and again just before the next frame begins to confirm they have held still.

Some faults show up only in particular frames:
- A counter that wraps instead of saturating shows only in a frame whose lines are longer than 4095 cycles.
- A min/max tracker that fails to clear shows in a frame with no video.
- A wrong channel OR shows in frames that drive a single channel.

The sweep covers each of these kinds of frame.

// File: rtl/hline_meas_pkg.sv
package hline_meas_pkg;
  localparam int NUM_MEAS    = 6;
  localparam int IDX_HSW     = 0;
  localparam int IDX_HPER    = 1;
  localparam int IDX_VSTART  = 2;
  localparam int IDX_VEND    = 3;
  localparam int IDX_FBSTART = 4;
  localparam int IDX_FBSTOP  = 5;

  localparam int NUM_EDGE = 3;
  localparam int EDGE_HS  = 0;
  localparam int EDGE_FB  = 1;
  localparam int EDGE_VID = 2;
endpackage

// File: rtl/hline_edge.sv
module hline_edge #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] sig_i,
  output logic [N-1:0] rise_o,
  output logic [N-1:0] fall_o
);
  for (genvar g = 0; g < N; g++) begin : g_bit
    logic prev_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= sig_i[g];
    end
    assign rise_o[g] = sig_i[g] & ~prev_q;
    assign fall_o[g] = ~sig_i[g] & prev_q;
  end
endmodule

// File: rtl/hline_ctr.sv
module hline_ctr #(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart_i,
  output logic [CNT_W-1:0] cur_o,
  output logic [CNT_W-1:0] inc_o
);
  localparam logic [CNT_W-1:0] MAXV = '1;

  logic [CNT_W-1:0] cnt_q;

  // saturating increment: held at MAXV once reached
  assign inc_o = (cnt_q == MAXV) ? MAXV : cnt_q + 1'b1;
  assign cur_o = restart_i ? '0 : inc_o;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= MAXV;
    else        cnt_q <= cur_o;
  end

  assert_count_rises_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !restart_i |=> cnt_q >= $past(cnt_q));
endmodule

// File: rtl/hline_frame_acc.sv
module hline_frame_acc
  import hline_meas_pkg::*;
#(
  parameter int CNT_W = 12
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              vsync_i,
  input  logic                              hs_rise_i,
  input  logic                              hs_fall_i,
  input  logic                              vid_rise_i,
  input  logic                              vid_fall_i,
  input  logic                              fb_rise_i,
  input  logic                              fb_fall_i,
  input  logic [CNT_W-1:0]                  cur_i,
  input  logic [CNT_W-1:0]                  inc_i,
  output logic [NUM_MEAS-1:0][CNT_W-1:0]    rd_o
);
  logic [NUM_MEAS-1:0][CNT_W-1:0] acc_q, acc_n, rd_q, rd_n;
  logic seen_q, seen_n;
  logic vs_prev_q, vs_rise;

  assign vs_rise = vsync_i & ~vs_prev_q;

  always_comb begin
    acc_n  = acc_q;
    seen_n = seen_q;
    if (vs_rise) begin
      acc_n             = '0;
      acc_n[IDX_VSTART] = '1;
      seen_n            = 1'b0;
    end
    if (hs_fall_i) acc_n[IDX_HSW]  = cur_i;
    if (hs_rise_i) acc_n[IDX_HPER] = inc_i;
    if (vid_rise_i) begin
      if (!seen_n || cur_i < acc_n[IDX_VSTART]) acc_n[IDX_VSTART] = cur_i;
      seen_n = 1'b1;
    end
    if (vid_fall_i && cur_i > acc_n[IDX_VEND]) acc_n[IDX_VEND] = cur_i;
    if (fb_rise_i) acc_n[IDX_FBSTART] = cur_i;
    if (fb_fall_i) acc_n[IDX_FBSTOP]  = cur_i;
  end

  always_comb begin
    rd_n = rd_q;
    if (vs_rise) begin
      rd_n = acc_q;
      if (!seen_q) rd_n[IDX_VSTART] = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q             <= '0;
      acc_q[IDX_VSTART] <= '1;
      seen_q            <= 1'b0;
      rd_q              <= '0;
      vs_prev_q         <= 1'b0;
    end else begin
      acc_q     <= acc_n;
      seen_q    <= seen_n;
      rd_q      <= rd_n;
      vs_prev_q <= vsync_i;
    end
  end

  assign rd_o = rd_q;

  assert_read_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !vs_rise |=> $stable(rd_q));
  assert_start_only_lowers_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!vs_rise && seen_q) |=> acc_q[IDX_VSTART] <= $past(acc_q[IDX_VSTART]));
  assert_end_only_raises_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !vs_rise |=> acc_q[IDX_VEND] >= $past(acc_q[IDX_VEND]));
  assert_no_video_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (vs_rise && !seen_q) |=> rd_q[IDX_VSTART] == '0);
endmodule

// File: rtl/hline_meas.sv
module hline_meas
  import hline_meas_pkg::*;
#(
  parameter int CNT_W = 12,
  parameter int OUT_W = 16,
  parameter int NCH   = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hsync_i,
  input  logic             vsync_i,
  input  logic             flyback_i,
  input  logic [NCH-1:0]   video_i,
  output logic [OUT_W-1:0] sync_width_o,
  output logic [OUT_W-1:0] line_period_o,
  output logic [OUT_W-1:0] video_start_o,
  output logic [OUT_W-1:0] video_end_o,
  output logic [OUT_W-1:0] flyback_start_o,
  output logic [OUT_W-1:0] flyback_end_o
);
  localparam int PAD = OUT_W - CNT_W;

  logic [NUM_EDGE-1:0]            edge_in, rise, fall;
  logic [CNT_W-1:0]               cur, inc;
  logic [NUM_MEAS-1:0][CNT_W-1:0] rd;

  assign edge_in[EDGE_HS]  = hsync_i;
  assign edge_in[EDGE_FB]  = flyback_i;
  assign edge_in[EDGE_VID] = |video_i;

  hline_edge #(.N(NUM_EDGE)) u_edge (
    .clk(clk), .rst_n(rst_n), .sig_i(edge_in), .rise_o(rise), .fall_o(fall)
  );

  hline_ctr #(.CNT_W(CNT_W)) u_ctr (
    .clk(clk), .rst_n(rst_n), .restart_i(rise[EDGE_HS]), .cur_o(cur), .inc_o(inc)
  );

  hline_frame_acc #(.CNT_W(CNT_W)) u_acc (
    .clk(clk), .rst_n(rst_n), .vsync_i(vsync_i),
    .hs_rise_i(rise[EDGE_HS]), .hs_fall_i(fall[EDGE_HS]),
    .vid_rise_i(rise[EDGE_VID]), .vid_fall_i(fall[EDGE_VID]),
    .fb_rise_i(rise[EDGE_FB]), .fb_fall_i(fall[EDGE_FB]),
    .cur_i(cur), .inc_i(inc), .rd_o(rd)
  );

  assign sync_width_o    = {rd[IDX_HSW],     {PAD{1'b0}}};
  assign line_period_o   = {rd[IDX_HPER],    {PAD{1'b0}}};
  assign video_start_o   = {rd[IDX_VSTART],  {PAD{1'b0}}};
  assign video_end_o     = {rd[IDX_VEND],    {PAD{1'b0}}};
  assign flyback_start_o = {rd[IDX_FBSTART], {PAD{1'b0}}};
  assign flyback_end_o   = {rd[IDX_FBSTOP],  {PAD{1'b0}}};
endmodule

// File: tb/tb_hline_meas.sv
`timescale 1ns/1ps
module tb_hline_meas;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hs = 1'b0, vs = 1'b0, fb = 1'b0;
  logic [2:0] vid = 3'b000;
  logic [15:0] o_hsw, o_hper, o_vst, o_vend, o_fbs, o_fbe;

  int checks = 0, fails = 0;
  int pend[6];
  int shown[6];
  string ptag[6];
  string stag[6];
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  hline_meas dut (
    .clk(clk), .rst_n(rst_n), .hsync_i(hs), .vsync_i(vs), .flyback_i(fb), .video_i(vid),
    .sync_width_o(o_hsw), .line_period_o(o_hper), .video_start_o(o_vst),
    .video_end_o(o_vend), .flyback_start_o(o_fbs), .flyback_end_o(o_fbe)
  );

  function automatic int sat(int v);
    return (v > 4095) ? 4095 : v;
  endfunction

  // R9: count in bits 15:4, low nibble zero
  function automatic logic [15:0] word(int v);
    logic [11:0] c = 12'(sat(v));
    return {c, 4'b0000};
  endfunction

  function automatic logic [15:0] get_out(int i);
    case (i)
      0: return o_hsw;
      1: return o_hper;
      2: return o_vst;
      3: return o_vend;
      4: return o_fbs;
      default: return o_fbe;
    endcase
  endfunction

  task automatic chk(string req, string what, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // R7: at frame start the previous frame's values appear
  task automatic check_frame_start();
    for (int i = 0; i < 6; i++) begin
      chk({ptag[i], "/R7"}, "frame result", get_out(i), word(pend[i]));
      shown[i] = pend[i];
      stag[i] = ptag[i];
    end
    chk("R9", "pad bits", {12'h000, o_hper[3:0]}, 16'h0000);
  endtask

  // R8: values held through the frame
  task automatic check_hold();
    for (int i = 0; i < 6; i++)
      chk("R8", "held value", get_out(i), word(shown[i]));
  endtask

  task automatic run_frame(int w, int p, int l, int a, int b, int f1, int f2,
                           logic [2:0] ch, string tag_sat);
    for (int ln = 0; ln < l; ln++) begin
      for (int c = 0; c < p; c++) begin
        @(negedge clk);
        if (ln == 0 && c == 1) begin
          check_frame_start();
          pend[0] = w;  ptag[0] = "R2";
          pend[1] = p;  ptag[1] = "R3";
          pend[2] = (ch != 0) ? a : 0;  ptag[2] = (ch != 0) ? "R4" : "R5";
          pend[3] = (ch != 0) ? b : 0;  ptag[3] = (ch != 0) ? "R4" : "R5";
          pend[4] = f1; ptag[4] = "R6";
          pend[5] = f2; ptag[5] = "R6";
          if (tag_sat != "")
            for (int i = 0; i < 6; i++) if (pend[i] > 4095) ptag[i] = tag_sat;
        end
        if (ln == l - 1 && c == p - 1) check_hold();
        hs  = (c < w);
        vs  = (ln == 0);
        fb  = (c >= f1) && (c < f2);
        vid = ((c >= a + (l - 1 - ln)) && (c < b - ln)) ? ch : 3'b000;
      end
    end
  endtask

  initial begin
    for (int i = 0; i < 6; i++) begin
      pend[i] = 0; shown[i] = 0; ptag[i] = "R8"; stag[i] = "R8";
    end
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    for (int i = 0; i < 6; i++) chk("R8", "reset value", get_out(i), 16'h0000);

    // sweep: sync width, line period, single channel each
    for (int w = 1; w <= 3; w++)
      for (int pi = 0; pi < 2; pi++)
        for (int ch = 0; ch < 3; ch++) begin
          int p = 24 + 7 * pi;
          run_frame(w, p, 3, w + 2 + ch, p - 3 - ch, w + 1 + pi, p - 2 - ch,
                    3'(1 << ch), "");
        end
    // R5: no video at all
    run_frame(2, 20, 3, 4, 15, 3, 17, 3'b000, "");
    // R4: all channels together
    run_frame(4, 40, 3, 7, 33, 6, 36, 3'b111, "");
    // R1: lines longer than the counter range saturate
    run_frame(3, 4200, 2, 10, 4150, 20, 4120, 3'b010, "R1");
    // flush frame so the saturated frame is read back
    run_frame(2, 22, 2, 5, 18, 4, 19, 3'b100, "");
    run_frame(2, 22, 2, 5, 18, 4, 19, 3'b100, "");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL R7 watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule